// File: doc/BRIEF.md
# Eight-bit end-around rotator

A purely combinational block that moves an 8-bit word toward higher bit positions by zero to seven places. A bit pushed past the most significant position comes back in at the least significant end, so the word behaves as a closed ring: nothing is dropped and nothing is filled in.

Internally the word is handled by two banks of 4-bit shifter slices. Each slice can move its nibble by 0 to 3 places, using three link bits taken from the positions just below it. The two low bits of the shift code steer every slice. The top bit of the code does not add a multiplexer stage. Instead it selects which bank may drive a shared result bus. The second bank receives its data already turned by four places, so together with the low code bits it covers amounts 4 to 7. The shared bus is modelled as an enable-gated OR, not as real tri-state nets.

Top module: `rotator8`

## Requirements
- R1: With shift code 3'b000, `data_o` equals `data_i` bit for bit.
- R2: For shift code n (binary, 0 to 7), output bit (k+n) mod 8 equals input bit k for every k.
- R3: The rotation is closed: a bit leaving position 7 reappears at position 0 (8'h80 with code 1 gives 8'h01), and the number of ones in `data_o` always equals that in `data_i`.
- R4: Exactly one slice bank drives the shared bus for any code: the low-range bank when code bit 2 is 0, the high-range bank when it is 1.
- R5: Codes 4 to 7 give the result of codes 0 to 3 applied to the word already turned by four places (8'h01 with code 4 gives 8'h10, and with code 7 gives 8'h80).
- R6: A single set bit at position k appears only at position (k+n) mod 8 for code n. The idle bank adds no stray bits to the bus.
- R7: The output follows any change of `data_i` or `shamt_i` without a clock. A new input pair is fully reflected before the next sampling point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 8 | Word to rotate |
| shamt_i | input | 3 | Rotation amount, binary, toward higher bit positions |
| data_o | output | 8 | Rotated word |

## Verification
Two effects meet in one evaluation when a code selects the upper bank and the word also has bits near the top. The four-place pre-turn and the slice wrap through the link bits then act on the same bits together. Walking-one patterns under all eight codes provoke this, and so do words such as 8'h80 and 8'hF0 with codes 5 to 7. Each result is judged against a rotation computed in the bench from shifts and an OR, and any stray or missing bit counts as a mismatch. A checker also confirms that only one bank drives the bus and that the count of ones is kept.

// File: rtl/rot_pkg.sv
package rot_pkg;
  localparam int unsigned DEF_WORD_W  = 8;
  localparam int unsigned DEF_SLICE_W = 4;

  // position on a ring of the given width
  function automatic int unsigned ring_idx(input int pos, input int width);
    return int'(unsigned'((pos % width + width) % width));
  endfunction
endpackage

// File: rtl/rot_slice.sv
module rot_slice #(
  parameter int unsigned SLICE_W = 4,
  localparam int unsigned LO_W   = $clog2(SLICE_W),
  localparam int unsigned EXT_W  = 2 * SLICE_W - 1
) (
  input  logic [SLICE_W-1:0] data_i,
  input  logic [SLICE_W-2:0] link_i,  // [SLICE_W-2] is the bit just below data_i[0]
  input  logic [LO_W-1:0]    sel_i,
  input  logic               oe_i,
  output logic [SLICE_W-1:0] dat_o,
  output logic               drv_o
);
  logic [EXT_W-1:0]   ext;
  logic [SLICE_W-1:0] shf;

  assign ext = {data_i, link_i};

  for (genvar k = 0; k < SLICE_W; k++) begin : g_bit
    always_comb begin
      shf[k] = 1'b0;
      for (int s = 0; s < SLICE_W; s++) begin
        if (sel_i == LO_W'(s)) shf[k] = ext[k + SLICE_W - 1 - s];
      end
    end
  end

  // bus model: disabled slice contributes zeros
  assign dat_o = shf & {SLICE_W{oe_i}};
  assign drv_o = oe_i;
endmodule

// File: rtl/rot_bank.sv
module rot_bank
  import rot_pkg::*;
#(
  parameter int unsigned WORD_W  = 8,
  parameter int unsigned SLICE_W = 4,
  parameter int unsigned PRE     = 0,
  localparam int unsigned LO_W   = $clog2(SLICE_W),
  localparam int unsigned NUM_SL = WORD_W / SLICE_W
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [LO_W-1:0]   sel_i,
  input  logic              en_i,
  output logic [WORD_W-1:0] bank_o,
  output logic              drv_o
);
  logic [WORD_W-1:0] pre;
  logic [NUM_SL-1:0] sl_drv;

  // fixed pre-turn by PRE places
  for (genvar i = 0; i < WORD_W; i++) begin : g_pre
    assign pre[ring_idx(i + PRE, WORD_W)] = word_i[i];
  end

  for (genvar j = 0; j < NUM_SL; j++) begin : g_sl
    logic [SLICE_W-2:0] link;
    for (genvar m = 0; m < SLICE_W - 1; m++) begin : g_lnk
      assign link[m] = pre[ring_idx(j * SLICE_W + m - (SLICE_W - 1), WORD_W)];
    end
    rot_slice #(.SLICE_W(SLICE_W)) u_sl (
      .data_i (pre[j*SLICE_W +: SLICE_W]),
      .link_i (link),
      .sel_i  (sel_i),
      .oe_i   (en_i),
      .dat_o  (bank_o[j*SLICE_W +: SLICE_W]),
      .drv_o  (sl_drv[j])
    );
  end

  assign drv_o = |sl_drv;
endmodule

// File: rtl/rot_bus.sv
module rot_bus #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][WORD_W-1:0] src_i,
  output logic [WORD_W-1:0]              bus_o
);
  always_comb begin
    bus_o = '0;
    for (int b = 0; b < NUM_SRC; b++) bus_o = bus_o | src_i[b];
  end
endmodule

// File: rtl/rotator8.sv
module rotator8
  import rot_pkg::*;
#(
  parameter int unsigned WORD_W  = DEF_WORD_W,
  parameter int unsigned SLICE_W = DEF_SLICE_W,
  localparam int unsigned SEL_W     = $clog2(WORD_W),
  localparam int unsigned LO_W      = $clog2(SLICE_W),
  localparam int unsigned HI_W      = SEL_W - LO_W,
  localparam int unsigned NUM_BANKS = WORD_W / SLICE_W
) (
  input  logic [WORD_W-1:0] data_i,
  input  logic [SEL_W-1:0]  shamt_i,
  output logic [WORD_W-1:0] data_o
);
  logic [HI_W-1:0]                     bank_code;
  logic [LO_W-1:0]                     lo_sel;
  logic [NUM_BANKS-1:0]                bank_en;
  logic [NUM_BANKS-1:0]                bank_drv;
  logic [NUM_BANKS-1:0][WORD_W-1:0]    bank_out;

  assign bank_code = shamt_i[SEL_W-1:LO_W];
  assign lo_sel    = shamt_i[LO_W-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_en[b] = (bank_code == HI_W'(b));
    rot_bank #(
      .WORD_W  (WORD_W),
      .SLICE_W (SLICE_W),
      .PRE     (b * SLICE_W)
    ) u_bank (
      .word_i (data_i),
      .sel_i  (lo_sel),
      .en_i   (bank_en[b]),
      .bank_o (bank_out[b]),
      .drv_o  (bank_drv[b])
    );
  end

  rot_bus #(.WORD_W(WORD_W), .NUM_SRC(NUM_BANKS)) u_bus (
    .src_i (bank_out),
    .bus_o (data_o)
  );
endmodule

// File: rtl/rotator8_chk.sv
module rotator8_chk #(
  parameter int unsigned WORD_W  = 8,
  parameter int unsigned SLICE_W = 4,
  localparam int unsigned SEL_W  = $clog2(WORD_W),
  localparam int unsigned LO_W   = $clog2(SLICE_W),
  localparam int unsigned NB     = WORD_W / SLICE_W
) (
  input logic [WORD_W-1:0] data_i,
  input logic [SEL_W-1:0]  shamt_i,
  input logic [WORD_W-1:0] data_o,
  input logic [NB-1:0]     bank_drv_i
);
  logic [WORD_W-1:0] ring_ref;

  always_comb begin
    ring_ref = '0;
    for (int a = 0; a < WORD_W; a++) begin
      if (shamt_i == SEL_W'(a)) begin
        for (int i = 0; i < WORD_W; i++) ring_ref[(i + a) % WORD_W] = data_i[i];
      end
    end
  end

  always_comb begin
    if (!$isunknown({data_i, shamt_i})) begin
      assert_zero_shift_R1: assert (shamt_i != '0 || data_o == data_i)
        else $error("R1 zero code changed word");
      assert_rotate_R2: assert (data_o == ring_ref)
        else $error("R2 rotate mismatch");
      assert_ones_kept_R3: assert ($countones(data_o) == $countones(data_i))
        else $error("R3 bit count changed");
      assert_one_bank_R4: assert ($countones(bank_drv_i) == 1)
        else $error("R4 bank drive not exclusive");
      assert_bank_pick_R5: assert (bank_drv_i[shamt_i[SEL_W-1:LO_W]])
        else $error("R5 wrong bank drives");
    end
  end
endmodule

bind rotator8 rotator8_chk #(.WORD_W(WORD_W), .SLICE_W(SLICE_W)) u_chk (
  .data_i     (data_i),
  .shamt_i    (shamt_i),
  .data_o     (data_o),
  .bank_drv_i (bank_drv)
);

// File: tb/sim_rotator8.sv
module sim_rotator8;
  typedef struct {
    logic [7:0] d;
    logic [2:0] n;
    logic [7:0] exp;
    string      req;
  } item_t;

  logic       clk = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic [2:0] shamt_i = 3'd0;
  logic [7:0] data_o;
  item_t      sb_q[$];
  int         n_run = 0;
  int         n_fail = 0;
  int         cyc = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rotator8 u0 (.data_i(data_i), .shamt_i(shamt_i), .data_o(data_o));

  function automatic logic [7:0] ref_rot(input logic [7:0] d, input logic [2:0] n);
    logic [15:0] w;
    w = {d, d} << n;
    return w[15:8];
  endfunction

  task automatic drive(input logic [7:0] d, input logic [2:0] n, input string req);
    item_t it;
    @(negedge clk);
    data_i  = d;
    shamt_i = n;
    it.d = d; it.n = n; it.exp = ref_rot(d, n); it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic drive_exp(input logic [7:0] d, input logic [2:0] n,
                           input logic [7:0] e, input string req);
    item_t it;
    @(negedge clk);
    data_i  = d;
    shamt_i = n;
    it.d = d; it.n = n; it.exp = e; it.req = req;
    sb_q.push_back(it);
  endtask

  // monitor: inputs change at negedge, compare at posedge
  always @(posedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_run++;
      if (data_o !== it.exp) begin
        n_fail++;
        $display("FAIL %s d=%h n=%0d actual=%h expected=%h", it.req, it.d, it.n, data_o, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=%0d cycles expected=<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // initial state: zero word, zero code (R1, R7)
    drive_exp(8'h00, 3'd0, 8'h00, "R1_init");
    drive_exp(8'hA5, 3'd0, 8'hA5, "R1");
    drive_exp(8'h3C, 3'd0, 8'h3C, "R1");
    drive_exp(8'h80, 3'd1, 8'h01, "R3_wrap");
    drive_exp(8'hC0, 3'd2, 8'h03, "R3_wrap");
    drive_exp(8'hFF, 3'd5, 8'hFF, "R3_all_ones");
    drive_exp(8'h01, 3'd4, 8'h10, "R5");
    drive_exp(8'h01, 3'd7, 8'h80, "R5");
    drive_exp(8'hF0, 3'd6, 8'h3C, "R5");
    drive_exp(8'h12, 3'd3, 8'h90, "R4_low_bank");
    drive_exp(8'h12, 3'd5, 8'h42, "R4_high_bank");
    drive_exp(8'h80, 3'd7, 8'h40, "R3_R5");
    // walking one under every code (R6, R2)
    for (int n = 0; n < 8; n++) begin
      for (int k = 0; k < 8; k++) begin
        drive(8'h01 << k, 3'(n), "R6");
      end
    end
    // walking zero
    for (int n = 0; n < 8; n++) begin
      for (int k = 0; k < 8; k++) begin
        drive(~(8'h01 << k), 3'(n), "R3_R6");
      end
    end
    // random words, every code, back-to-back changes (R2, R7)
    for (int r = 0; r < 40; r++) begin
      logic [7:0] d;
      d = 8'($urandom);
      for (int n = 0; n < 8; n++) drive(d, 3'(n), "R2_R7");
    end
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule